// File: doc/BRIEF.md
# Delta-Sigma Converter Read Sequencer

This block runs a single-channel 22-bit delta-sigma converter that sits on a serial peripheral bus. The host raises a one-cycle start request. The block then drops chip select for a short interval, with the serial clock held still, to begin a conversion. It releases chip select and waits out the conversion time, counted in system clocks. After that it clocks the output frame in and turns the flag bits into a signed 32-bit value, or into an error indication.

The bus mode is fixed at build time. In mode 0,0 the converter sends a data-ready bit ahead of the 24 data bits, so the frame is 25 clocks long and that leading bit is dropped. In mode 1,1 the frame is 24 clocks long. Leaving reset, the block runs two complete conversions back to back and reports neither of them. This brings a converter that was left in shutdown back to a known state. Start requests are ignored while the block is busy.

Top module: `dsadc_seq`

## Requirements
- R1: After reset the block runs exactly two conversions, giving four chip-select low intervals. It raises no result strobe for them and holds busy_o high until they are done.
- R2: A conversion begins with chip select low for exactly START_PULSE_CYC clocks, with no serial clock edge during that interval.
- R3: Between the end of the start interval and the start of the read, chip select stays high for at least CONV_WAIT_CYC clocks.
- R4: The serial clock idles at the CPOL level whenever chip select is high. A read gives 25 rising clock edges when CPOL=0 and 24 when CPOL=1. In the CPOL=0 case the first bit is discarded, and data is taken MSB first.
- R5: When raw bits 23, 22 and 21 are all clear, the result is raw[21:0] zero-extended to 32 bits.
- R6: When bit 22 is clear and bit 23 or bit 21 is set (underrange or negative), the result is raw[21:0] with bits 31:22 set to one.
- R7: When only bit 22 of bits 23:22 is set (overrange), that bit is cleared and raw[21:0] is output as a positive value, whatever bit 21 holds.
- R8: When bits 23 and 22 are both set, result_err_o is 1 on the strobe and result_o is 0.
- R9: Every reported conversion raises result_valid_o for exactly one clock, with result_err_o valid in that same clock.
- R10: A start request made while a conversion is running has no effect: it adds no chip-select interval and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request, sampled while idle |
| spi_miso_i | input | 1 | Serial data from the converter |
| spi_cs_n_o | output | 1 | Chip select, active low |
| spi_sclk_o | output | 1 | Serial clock |
| busy_o | output | 1 | High while a sequence is running |
| result_valid_o | output | 1 | One-cycle result strobe |
| result_err_o | output | 1 | Both range flags set; result not valid |
| result_o | output | 32 | Signed conversion result |

## Verification
The decoder is driven with raw frames from each flag class: plain positive, in-range negative (including the extreme codes), underrange, overrange with and without bit 21, and both range flags together, including the all-ones frame that a stuck converter returns. Together these show that each flag is given the right priority, that bit 22 is cleared only for overrange, and that sign filling comes only from bit 23 or bit 21. Two instances, one for each bus mode, get the same frames. Matching results from both show that the ready bit is dropped in mode 0,0 and that no bit is lost in mode 1,1. The chip-select interval lengths and the clock-edge counts tell the start pulse apart from the read.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

    localparam int RAW_W  = 24;
    localparam int RES_W  = 32;
    localparam int MAG_W  = 22;
    localparam int FILL_W = RES_W - MAG_W;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_IDLE,
        ST_PULSE,
        ST_WAIT,
        ST_READ,
        ST_REL
    } seq_state_e;

    typedef struct packed {
        logic             err;
        logic [RES_W-1:0] value;
    } conv_res_t;

    // number of serial clocks in one read frame for a given idle polarity
    function automatic int frame_bits(input bit cpol);
        return cpol ? RAW_W : RAW_W + 1;
    endfunction

    // flag decode: bit23 underrange, bit22 overrange, bit21 in-range sign
    function automatic conv_res_t decode_raw(input logic [RAW_W-1:0] raw);
        conv_res_t r;
        r.err   = 1'b0;
        r.value = '0;
        if (raw[23] && raw[22]) begin
            r.err = 1'b1;
        end else if (raw[22]) begin
            r.value = {{FILL_W{1'b0}}, raw[MAG_W-1:0]};
        end else if (raw[23] || raw[21]) begin
            r.value = {{FILL_W{1'b1}}, raw[MAG_W-1:0]};
        end else begin
            r.value = {{FILL_W{1'b0}}, raw[MAG_W-1:0]};
        end
        return r;
    endfunction

endpackage

// File: rtl/dsadc_ticker.sv
module dsadc_ticker #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/dsadc_rx.sv
module dsadc_rx
    import dsadc_pkg::*;
#(
    parameter bit CPOL     = 1'b0,
    parameter int HALF_CYC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             miso,
    output logic             sclk,
    output logic             done,
    output logic [RAW_W-1:0] word
);

    localparam int   NBITS    = frame_bits(CPOL);
    localparam int   HW       = $clog2(HALF_CYC + 1);
    localparam int   BW       = $clog2(NBITS + 1);
    localparam logic IDLE_LVL = CPOL;
    localparam logic [HW-1:0] HALF_LD = HW'(HALF_CYC - 1);
    localparam logic [BW-1:0] BITS_LD = BW'(NBITS);

    logic             busy_q;
    logic             phase_q;
    logic [HW-1:0]    half_q;
    logic [BW-1:0]    bits_q;
    logic [RAW_W-1:0] sr_q;
    logic             sclk_q;
    logic             done_q;

    // The register is RAW_W wide; with a 25-bit frame the leading
    // ready bit falls off the top on the last shift.
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            phase_q <= 1'b0;
            half_q  <= '0;
            bits_q  <= '0;
            sr_q    <= '0;
            sclk_q  <= IDLE_LVL;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q  <= 1'b1;
                    phase_q <= 1'b0;
                    half_q  <= HALF_LD;
                    bits_q  <= BITS_LD;
                    sclk_q  <= 1'b0;
                end
            end else if (half_q != '0) begin
                half_q <= half_q - 1'b1;
            end else if (!phase_q) begin
                phase_q <= 1'b1;
                sclk_q  <= 1'b1;
                sr_q    <= {sr_q[RAW_W-2:0], miso};
                bits_q  <= bits_q - 1'b1;
                half_q  <= HALF_LD;
            end else if (bits_q == '0) begin
                busy_q  <= 1'b0;
                phase_q <= 1'b0;
                sclk_q  <= IDLE_LVL;
                done_q  <= 1'b1;
            end else begin
                phase_q <= 1'b0;
                sclk_q  <= 1'b0;
                half_q  <= HALF_LD;
            end
        end
    end

    assign sclk = sclk_q;
    assign done = done_q;
    assign word = sr_q;

    // R4: a frame always ends right after a high clock phase
    assert_frame_end_R4: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $past(sclk_q) == 1'b1);

endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
    import dsadc_pkg::*;
#(
    parameter bit CPOL            = 1'b0,
    parameter int START_PULSE_CYC = 400,
    parameter int CONV_WAIT_CYC   = 4_200_000,
    parameter int SCLK_HALF_CYC   = 25,
    parameter int WAKE_CONVS      = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             spi_miso_i,
    output logic             spi_cs_n_o,
    output logic             spi_sclk_o,
    output logic             busy_o,
    output logic             result_valid_o,
    output logic             result_err_o,
    output logic [RES_W-1:0] result_o
);

    localparam int   TMAX     = (START_PULSE_CYC > CONV_WAIT_CYC) ? START_PULSE_CYC : CONV_WAIT_CYC;
    localparam int   TW       = $clog2(TMAX + 1);
    localparam int   WK_W     = $clog2(WAKE_CONVS + 1);
    localparam logic IDLE_LVL = CPOL;
    localparam logic [TW-1:0]   PULSE_LD = TW'(START_PULSE_CYC - 1);
    localparam logic [TW-1:0]   WAIT_LD  = TW'(CONV_WAIT_CYC - 1);
    localparam logic [WK_W-1:0] WAKE_LD  = WK_W'(WAKE_CONVS);

    seq_state_e        state_q, state_d;
    logic [WK_W-1:0]   wake_q;
    logic              tmr_load;
    logic [TW-1:0]     tmr_val;
    logic              tmr_expired;
    logic              rx_start;
    logic              rx_done;
    logic [RAW_W-1:0]  rx_word;
    logic              valid_q;
    logic              err_q;
    logic [RES_W-1:0]  value_q;
    conv_res_t         dec;

    dsadc_ticker #(.W(TW)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    dsadc_rx #(.CPOL(CPOL), .HALF_CYC(SCLK_HALF_CYC)) u_rx (
        .clk   (clk),
        .rst   (rst),
        .start (rx_start),
        .miso  (spi_miso_i),
        .sclk  (spi_sclk_o),
        .done  (rx_done),
        .word  (rx_word)
    );

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = PULSE_LD;
        rx_start = 1'b0;
        case (state_q)
            ST_BOOT: begin
                state_d  = ST_PULSE;
                tmr_load = 1'b1;
            end
            ST_IDLE: begin
                if (start_i) begin
                    state_d  = ST_PULSE;
                    tmr_load = 1'b1;
                end
            end
            ST_PULSE: begin
                if (tmr_expired) begin
                    state_d  = ST_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = WAIT_LD;
                end
            end
            ST_WAIT: begin
                if (tmr_expired) begin
                    state_d  = ST_READ;
                    rx_start = 1'b1;
                end
            end
            ST_READ: begin
                if (rx_done) state_d = ST_REL;
            end
            ST_REL: begin
                if (wake_q != '0) begin
                    state_d  = ST_PULSE;
                    tmr_load = 1'b1;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign dec = decode_raw(rx_word);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_BOOT;
            wake_q  <= WAKE_LD;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
            value_q <= '0;
        end else begin
            state_q <= state_d;
            valid_q <= 1'b0;
            if (state_q == ST_READ && rx_done) begin
                if (wake_q != '0) begin
                    wake_q <= wake_q - 1'b1;
                end else begin
                    valid_q <= 1'b1;
                    err_q   <= dec.err;
                    value_q <= dec.value;
                end
            end
        end
    end

    assign spi_cs_n_o     = !(state_q == ST_PULSE || state_q == ST_READ);
    assign busy_o         = (state_q != ST_IDLE);
    assign result_valid_o = valid_q;
    assign result_err_o   = err_q;
    assign result_o       = value_q;

    // R1: wake-up conversions never raise the strobe
    assert_wake_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (wake_q != '0) |-> !valid_q);

    // R2: the start interval ends only when the timer has run out
    assert_pulse_len_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && $past(state_q) == ST_PULSE) |-> $past(tmr_expired));

    // R3: the read begins only after the full wait
    assert_wait_len_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_READ && $past(state_q) == ST_WAIT) |-> $past(tmr_expired));

    // R4: serial clock rests at its idle level while deselected
    assert_idle_clock_R4: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n_o |-> (spi_sclk_o == IDLE_LVL));

    // R6: a negative result carries a full sign fill
    assert_sign_fill_R6: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !err_q && value_q[RES_W-1]) |-> (&value_q[RES_W-2:MAG_W]));

    // R8: an error result carries a zero value
    assert_err_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (valid_q && err_q) |-> (value_q == '0));

    // R9: the strobe lasts one clock
    assert_single_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);

    // R10: a new start interval is entered only from idle, boot or release
    assert_no_restart_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PULSE && $past(state_q) != ST_PULSE) |->
        ($past(state_q) == ST_IDLE || $past(state_q) == ST_REL || $past(state_q) == ST_BOOT));

endmodule

// File: tb/sim_dsadc_seq.sv
module sim_adc_model #(
    parameter bit CPOL = 1'b0
) (
    input  logic        cs_n,
    input  logic        sclk,
    input  logic [23:0] word,
    output logic        miso
);
    int idx = 0;
    logic [24:0] frame25;

    assign frame25 = {1'b0, word};

    always @(negedge sclk or posedge cs_n) begin
        if (cs_n) idx <= 0;
        else      idx <= idx + 1;
    end

    always_comb begin
        if (cs_n) begin
            miso = 1'b1;
        end else if (!CPOL) begin
            miso = (idx <= 24) ? frame25[24 - idx] : 1'b1;
        end else begin
            miso = (idx >= 1 && idx <= 24) ? word[24 - idx] : 1'b1;
        end
    end
endmodule

module sim_dsadc_seq;
    localparam int PULSE_C = 8;
    localparam int WAIT_C  = 40;
    localparam int HALF_C  = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [23:0] word = 24'h0;

    logic cs0, sck0, miso0, busy0, v0, e0;
    logic cs1, sck1, miso1, busy1, v1, e1;
    logic [31:0] r0, r1;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    dsadc_seq #(.CPOL(1'b0), .START_PULSE_CYC(PULSE_C), .CONV_WAIT_CYC(WAIT_C),
                .SCLK_HALF_CYC(HALF_C), .WAKE_CONVS(2)) u0 (
        .clk(clk), .rst(rst), .start_i(start), .spi_miso_i(miso0),
        .spi_cs_n_o(cs0), .spi_sclk_o(sck0), .busy_o(busy0),
        .result_valid_o(v0), .result_err_o(e0), .result_o(r0));

    dsadc_seq #(.CPOL(1'b1), .START_PULSE_CYC(PULSE_C), .CONV_WAIT_CYC(WAIT_C),
                .SCLK_HALF_CYC(HALF_C), .WAKE_CONVS(2)) u1 (
        .clk(clk), .rst(rst), .start_i(start), .spi_miso_i(miso1),
        .spi_cs_n_o(cs1), .spi_sclk_o(sck1), .busy_o(busy1),
        .result_valid_o(v1), .result_err_o(e1), .result_o(r1));

    sim_adc_model #(.CPOL(1'b0)) m0 (.cs_n(cs0), .sclk(sck0), .word(word), .miso(miso0));
    sim_adc_model #(.CPOL(1'b1)) m1 (.cs_n(cs1), .sclk(sck1), .word(word), .miso(miso1));

    // monitor
    logic clr_req = 1'b0;
    int falls0, nseg, lrun, hrun, hi_seen, rise0, rise1;
    int vcnt0, vcnt1, vrun, vmax;
    int seg_lo [8];
    int seg_hi [8];
    logic [31:0] res0, res1;
    logic err0, err1;
    logic pcs0 = 1'b1, psck0 = 1'b0, psck1 = 1'b1;

    always @(negedge clk) begin
        if (clr_req) begin
            falls0 = 0; nseg = 0; lrun = 0; hrun = 0; hi_seen = 0;
            rise0 = 0; rise1 = 0; vcnt0 = 0; vcnt1 = 0; vrun = 0; vmax = 0;
            for (int k = 0; k < 8; k++) begin seg_lo[k] = 0; seg_hi[k] = 0; end
        end else if (!rst) begin
            if (!cs0) begin
                if (pcs0) begin falls0++; hi_seen = hrun; lrun = 0; end
                lrun++;
            end else begin
                if (!pcs0) begin
                    if (nseg < 8) begin seg_lo[nseg] = lrun; seg_hi[nseg] = hi_seen; end
                    nseg++;
                    hrun = 0;
                end
                hrun++;
            end
            if (sck0 && !psck0 && !cs0) rise0++;
            if (sck1 && !psck1 && !cs1) rise1++;
            if (v0) begin
                vcnt0++; res0 = r0; err0 = e0; vrun++;
                if (vrun > vmax) vmax = vrun;
            end else begin
                vrun = 0;
            end
            if (v1) begin vcnt1++; res1 = r1; err1 = e1; end
        end
        pcs0 = cs0; psck0 = sck0; psck1 = sck1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_ge(input string req, input int act, input int lim);
        tests++;
        if (act < lim) begin
            fails++;
            $display("FAIL %s: actual %0d expected >= %0d", req, act, lim);
        end
    endtask

    task automatic clear_mon();
        @(negedge clk); #1 clr_req = 1'b1;
        @(negedge clk); #1 clr_req = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); #1 start = 1'b1;
        @(negedge clk); #1 start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (vcnt0 >= 1 && vcnt1 >= 1 && !busy0 && !busy1) break;
        end
        repeat (5) @(negedge clk);
    endtask

    // expected decode written from the requirements
    task automatic expect_of(input logic [23:0] w, output logic [31:0] val, output logic err);
        err = 1'b0;
        val = 32'h0;
        if (w[23] == 1'b1 && w[22] == 1'b1) err = 1'b1;                  // R8
        else if (w[22] == 1'b1) val = {10'h000, w[21:0]};                // R7
        else if (w[23] == 1'b1 || w[21] == 1'b1) val = {10'h3FF, w[21:0]}; // R6
        else val = {10'h000, w[21:0]};                                   // R5
    endtask

    task automatic run_conv(input string req, input logic [23:0] w);
        logic [31:0] ev;
        logic ee;
        expect_of(w, ev, ee);
        word = w;
        clear_mon();
        pulse_start();
        wait_done();
        check({req, " value mode0"}, res0, ev);
        check({req, " err mode0"}, {31'h0, err0}, {31'h0, ee});
        check({req, " value mode1"}, res1, ev);
        check({req, " err mode1"}, {31'h0, err1}, {31'h0, ee});
        check("R9 strobe width", vmax, 1);
        check("R2 start interval", seg_lo[0], PULSE_C);
        check_ge("R3 wait", seg_hi[1], WAIT_C);
        check("R4 edges mode0", rise0, 25);
        check("R4 edges mode1", rise1, 24);
    endtask

    task automatic t_reset_wake();
        clear_mon();
        repeat (3) @(negedge clk);
        check("R1 reset cs", {31'h0, cs0}, 32'h1);
        check("R1 reset valid", {31'h0, v0}, 32'h0);
        word = 24'hFFFFFF;
        @(negedge clk); #1 rst = 1'b0;
        #1 start = 1'b1;
        @(negedge clk); #1 start = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (!busy0 && !busy1) break;
        end
        repeat (5) @(negedge clk);
        check("R1 wake intervals", falls0, 4);
        check("R1 wake no strobe", vcnt0 + vcnt1, 0);
        check("R1 idle after wake", {30'h0, busy0, busy1}, 32'h0);
    endtask

    task automatic t_busy_ignore();
        word = 24'h000777;
        clear_mon();
        pulse_start();
        repeat (20) @(negedge clk);
        pulse_start();
        wait_done();
        repeat (300) @(negedge clk);
        check("R10 strobes", vcnt0, 1);
        check("R10 intervals", falls0, 2);
        check("R10 value", res0, 32'h00000777);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected < 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        t_reset_wake();
        run_conv("R5 positive", 24'h012345);
        run_conv("R5 max positive", 24'h1FFFFF);
        run_conv("R6 negative extreme", 24'h200000);
        run_conv("R6 minus one", 24'h3FFFFF);
        run_conv("R6 underrange", 24'h800010);
        run_conv("R7 overrange", 24'h400005);
        run_conv("R7 overrange bit21", 24'h600001);
        run_conv("R8 both flags", 24'hC00000);
        run_conv("R8 all ones", 24'hFFFFFF);
        run_conv("R5 zero after error", 24'h000000);
        t_busy_ignore();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule